// File: doc/BRIEF.md
# Cell Bus Event Status and Interrupt Register

This block gathers single-cycle event pulses from the datapath of a cell-switching bus interface and keeps each of them as a sticky bit in an 8-bit status word. The events are a header CRC-4 mismatch, an overflow of the control receive queue, arrival of a control cell, an inlet start-of-cell framing error, completion of a processor-requested control cell transmission, a bus grant timeout and an outlet queue overflow. A single interrupt line is raised while any status bit is set and its matching bit in an 8-bit enable register is also set.

Two small trackers sit inside the block. The first counts frame pulses while a bus request waits for a grant and flags a timeout after a programmable number of frames. The second tracks how many cells the four-entry control receive queue holds, so that the block can detect a fifth arrival itself. The header CRC comparison is also done here: the datapath supplies the received and the locally calculated 4-bit check values.

A processor reaches four registers through a simple synchronous write port and a combinational read port: the status word, the interrupt enables, the grant timeout limit and a command/occupancy register. The asynchronous active-low reset is synchronised inside the block before it reaches any register.

Top module: `cbus_status_reg`

## Requirements
- R1: After reset the status word (address 0) and enables (address 1) read 0, the timeout limit (address 2) reads the parameter LIMIT_RST (default 4), the occupancy (address 3, bits 2:0) reads 0 and irq is 0.
- R2: When hdr_chk is high and hdr_crc_rx differs from hdr_crc_calc, status bit 7 is set at the next clock edge; when the two values match no bit changes.
- R3: The control queue holds at most 4 cells; a cq_push while it holds 4 and no cell leaves in the same cycle sets status bit 6 and leaves the occupancy at 4.
- R4: An accepted cq_push sets status bit 5 and raises the occupancy by one; bit 5 is not cleared by writing 1 to it at address 0, and is cleared only by writing 1 to bit 0 of address 3, which also removes one cell if the queue is not empty.
- R5: A pulse on inlet_soc_err, ctl_sent or outlet_ovf sets status bit 4, 3 or 0 respectively.
- R6: Writing 1 to bit 7, 6, 4, 3, 2 or 0 of address 0 clears that bit; writing 0 leaves it unchanged.
- R7: When a set event and a clear of the same bit (write-1 or acknowledge) meet in one cycle, the bit ends set.
- R8: irq is high exactly when some status bit and the same bit of the enable register (address 1) are both 1.
- R9: While bus_req is held and no grant arrives, status bit 2 is set on the N-th frame_tick, N being the limit at address 2 (a limit of 0 acts as 1).
- R10: The grant timeout is reported only once per request; bus_gnt or a drop of bus_req restarts the frame count from zero.
- R11: Status bit 1 is reserved: it always reads 0, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_chk | input | 1 | A received header CRC pair is valid this cycle |
| hdr_crc_rx | input | 4 | CRC-4 field carried in the received header |
| hdr_crc_calc | input | 4 | CRC-4 calculated over the received header |
| cq_push | input | 1 | A control cell tries to enter the control receive queue |
| inlet_soc_err | input | 1 | Inlet start-of-cell framing error pulse |
| ctl_sent | input | 1 | Requested control cell has been transmitted |
| outlet_ovf | input | 1 | Outlet queue overflow pulse |
| bus_req | input | 1 | Bus request pending (level) |
| bus_gnt | input | 1 | Bus grant received (pulse) |
| frame_tick | input | 1 | One pulse per bus frame |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the register at addr |
| irq | output | 1 | Interrupt request |

## Verification
The embedded properties watch every cycle that a set pulse always leaves its bit set on the next edge, that a set bit survives any cycle without a clear, that the queue occupancy never passes four and does not move on an overflow, and that the grant timeout fires at most once and only on a frame pulse with a request pending. Which pulse lands on which bit position, the exact frame count before a timeout, the reserved bit staying 0, acknowledge-only clearing of the cell-available bit and the interrupt masking can only be shown by the bench's scenarios, which read the registers back through the processor port.

// File: rtl/cbus_stat_pkg.sv
package cbus_stat_pkg;
  localparam int REG_W   = 8;
  // status bit positions (MSB first order is part of the register contract)
  localparam int B_CRC   = 7;
  localparam int B_CQOVF = 6;
  localparam int B_CAV   = 5;
  localparam int B_SOC   = 4;
  localparam int B_SENT  = 3;
  localparam int B_NOGNT = 2;
  localparam int B_RSVD  = 1;
  localparam int B_OOVF  = 0;

  localparam logic [REG_W-1:0] RSVD_MASK = 8'h02;
  localparam logic [REG_W-1:0] CAV_MASK  = 8'h20;

  typedef enum logic [1:0] {
    A_STATUS = 2'd0,
    A_ENABLE = 2'd1,
    A_LIMIT  = 2'd2,
    A_CMD    = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/cbus_grant_timer.sv
module cbus_grant_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             gnt,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             timeout
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fired_q, fired_d;
  logic [CNT_W-1:0] lim_eff;
  logic             armed, hit;

  always_comb begin
    lim_eff = (limit == '0) ? CNT_W'(1) : limit;
    armed   = req && !gnt && !fired_q;
    hit     = armed && tick && (({1'b0, cnt_q} + 1'b1) >= {1'b0, lim_eff});
    timeout = hit;
  end

  always_comb begin
    cnt_d   = cnt_q;
    fired_d = fired_q;
    if (!req || gnt) begin
      cnt_d   = '0;
      fired_d = 1'b0;
    end else if (hit) begin
      cnt_d   = '0;
      fired_d = 1'b1;
    end else if (armed && tick) begin
      cnt_d   = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      fired_q <= fired_d;
    end
  end

  p_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !timeout);
  p_needs_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (tick && req && !gnt));
endmodule

// File: rtl/cbus_ctlq_track.sv
module cbus_ctlq_track #(
  parameter int DEPTH = 4,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             ack,
  output logic             accept,
  output logic             overflow,
  output logic [OCC_W-1:0] occ
);
  logic [OCC_W-1:0] occ_q, occ_d;
  logic             pop_ok, room;

  always_comb begin
    pop_ok   = ack && (occ_q != '0);
    room     = (occ_q < OCC_W'(DEPTH)) || pop_ok;
    accept   = push && room;
    overflow = push && !room;
    occ_d    = occ_q;
    if (accept && !pop_ok)      occ_d = occ_q + 1'b1;
    else if (!accept && pop_ok) occ_d = occ_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_q <= '0;
    else        occ_q <= occ_d;
  end

  assign occ = occ_q;

  p_occ_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= OCC_W'(DEPTH));
  p_ovf_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> (occ_q == OCC_W'(DEPTH)));
endmodule

// File: rtl/cbus_sticky_bank.sv
module cbus_sticky_bank #(
  parameter int                W    = 8,
  parameter logic [W-1:0]      RSVD = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] status
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (RSVD[i]) begin : g_rsvd
      assign status[i] = 1'b0;
    end else begin : g_live
      logic bit_q, bit_d;
      always_comb bit_d = set_vec[i] || (bit_q && !clr_vec[i]);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= bit_d;
      end
      assign status[i] = bit_q;

      p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[i] |=> status[i]);
      p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (status[i] && !clr_vec[i]) |=> status[i]);
    end
  end
endmodule

// File: rtl/cbus_status_reg.sv
module cbus_status_reg
  import cbus_stat_pkg::*;
#(
  parameter int             CQ_DEPTH  = 4,
  parameter int             LIM_W     = 8,
  parameter logic [LIM_W-1:0] LIMIT_RST = 8'd4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hdr_chk,
  input  logic [3:0]       hdr_crc_rx,
  input  logic [3:0]       hdr_crc_calc,
  input  logic             cq_push,
  input  logic             inlet_soc_err,
  input  logic             ctl_sent,
  input  logic             outlet_ovf,
  input  logic             bus_req,
  input  logic             bus_gnt,
  input  logic             frame_tick,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic             irq
);
  localparam int OCC_W = $clog2(CQ_DEPTH + 1);

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic             wr_stat, wr_en_reg, wr_lim, ack;
  logic [REG_W-1:0] en_q, en_d;
  logic [LIM_W-1:0] lim_q, lim_d;
  logic [REG_W-1:0] set_vec, clr_vec, status;
  logic             cq_accept, cq_ovf, nognt_ev;
  logic [OCC_W-1:0] occ;

  always_comb begin
    wr_stat   = wr_en && (addr == A_STATUS);
    wr_en_reg = wr_en && (addr == A_ENABLE);
    wr_lim    = wr_en && (addr == A_LIMIT);
    ack       = wr_en && (addr == A_CMD) && wdata[0];
  end

  cbus_grant_timer #(.CNT_W(LIM_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .req     (bus_req),
    .gnt     (bus_gnt),
    .tick    (frame_tick),
    .limit   (lim_q),
    .timeout (nognt_ev)
  );

  cbus_ctlq_track #(.DEPTH(CQ_DEPTH)) u_ctlq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .push     (cq_push),
    .ack      (ack),
    .accept   (cq_accept),
    .overflow (cq_ovf),
    .occ      (occ)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[B_CRC]   = hdr_chk && (hdr_crc_rx != hdr_crc_calc);
    set_vec[B_CQOVF] = cq_ovf;
    set_vec[B_CAV]   = cq_accept;
    set_vec[B_SOC]   = inlet_soc_err;
    set_vec[B_SENT]  = ctl_sent;
    set_vec[B_NOGNT] = nognt_ev;
    set_vec[B_OOVF]  = outlet_ovf;
    clr_vec          = wr_stat ? (wdata & ~CAV_MASK) : '0;
    clr_vec[B_CAV]   = ack;
  end

  cbus_sticky_bank #(.W(REG_W), .RSVD(RSVD_MASK)) u_bits (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .status  (status)
  );

  always_comb begin
    en_d  = wr_en_reg ? wdata : en_q;
    lim_d = wr_lim ? wdata[LIM_W-1:0] : lim_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      en_q  <= '0;
      lim_q <= LIMIT_RST;
    end else begin
      en_q  <= en_d;
      lim_q <= lim_d;
    end
  end

  always_comb begin
    irq = |(status & en_q);
    unique case (addr)
      A_STATUS: rdata = status;
      A_ENABLE: rdata = en_q;
      A_LIMIT:  rdata = REG_W'(lim_q);
      default:  rdata = REG_W'(occ);
    endcase
  end

  p_cav_ack_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ack && !cq_accept) |=> !status[B_CAV]);
  p_cav_w1c_ignored_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (status[B_CAV] && !ack) |=> status[B_CAV]);
endmodule

// File: tb/cbus_status_reg_test.sv
module cbus_status_reg_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hdr_chk = 0;
  logic [3:0] hdr_crc_rx = 0, hdr_crc_calc = 0;
  logic       cq_push = 0, inlet_soc_err = 0, ctl_sent = 0, outlet_ovf = 0;
  logic       bus_req = 0, bus_gnt = 0, frame_tick = 0;
  logic       wr_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic       irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  cbus_status_reg uut (
    .clk(clk), .rst_n(rst_n), .hdr_chk(hdr_chk), .hdr_crc_rx(hdr_crc_rx),
    .hdr_crc_calc(hdr_crc_calc), .cq_push(cq_push), .inlet_soc_err(inlet_soc_err),
    .ctl_sent(ctl_sent), .outlet_ovf(outlet_ovf), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .frame_tick(frame_tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // {hdr_chk, rx[3:0], calc[3:0], soc, sent, oovf, expected status[7:0]}
  localparam logic [19:0] VEC [0:7] = '{
    {1'b1, 4'h3, 4'h5, 1'b0, 1'b0, 1'b0, 8'h80},
    {1'b1, 4'hA, 4'hA, 1'b0, 1'b0, 1'b0, 8'h00},
    {1'b0, 4'h1, 4'h2, 1'b0, 1'b0, 1'b0, 8'h00},
    {1'b0, 4'h0, 4'h0, 1'b1, 1'b0, 1'b0, 8'h10},
    {1'b0, 4'h0, 4'h0, 1'b0, 1'b1, 1'b0, 8'h08},
    {1'b0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, 8'h01},
    {1'b1, 4'hF, 4'h0, 1'b1, 1'b1, 1'b1, 8'h99},
    {1'b1, 4'h7, 4'h7, 1'b1, 1'b0, 1'b1, 8'h11}
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, input string req, input logic [7:0] exp);
    addr = a;
    #0.5;
    check(req, rdata, exp);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); frame_tick = 1;
      @(negedge clk); frame_tick = 0;
    end
  endtask

  task automatic push1();
    @(negedge clk); cq_push = 1;
    @(negedge clk); cq_push = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(0, "R1 status", 8'h00);
    rd(1, "R1 enable", 8'h00);
    rd(2, "R1 limit", 8'h04);
    rd(3, "R1 occupancy", 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);

    // R2 R5 vector table
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      {hdr_chk, hdr_crc_rx, hdr_crc_calc, inlet_soc_err, ctl_sent, outlet_ovf} = VEC[v][19:8];
      @(negedge clk);
      {hdr_chk, inlet_soc_err, ctl_sent, outlet_ovf} = 4'b0;
      rd(0, "R2/R5 vector", VEC[v][7:0]);
      wr(0, 8'hDF);
      rd(0, "R6 clear after vector", 8'h00);
    end

    // R6 writing 0 keeps bits
    @(negedge clk); ctl_sent = 1; outlet_ovf = 1;
    @(negedge clk); ctl_sent = 0; outlet_ovf = 0;
    wr(0, 8'h00);
    rd(0, "R6 write zero", 8'h09);
    wr(0, 8'h08);
    rd(0, "R6 partial clear", 8'h01);
    wr(0, 8'h01);

    // R7 set wins over write-1-clear
    @(negedge clk); inlet_soc_err = 1; wr_en = 1; addr = 0; wdata = 8'h10;
    @(negedge clk); inlet_soc_err = 0; wr_en = 0;
    rd(0, "R7 set beats clear", 8'h10);
    wr(0, 8'h10);

    // R8 interrupt masking
    wr(1, 8'h08);
    rd(1, "R8 enable readback", 8'h08);
    check("R8 irq idle", {7'b0, irq}, 8'h00);
    @(negedge clk); outlet_ovf = 1;
    @(negedge clk); outlet_ovf = 0;
    #0.5 check("R8 irq masked bit", {7'b0, irq}, 8'h00);
    @(negedge clk); ctl_sent = 1;
    @(negedge clk); ctl_sent = 0;
    #0.5 check("R8 irq enabled bit", {7'b0, irq}, 8'h01);
    wr(1, 8'h00);
    #0.5 check("R8 irq after disable", {7'b0, irq}, 8'h00);
    wr(0, 8'hFF);

    // R3 R4 control queue
    for (int k = 0; k < 4; k++) push1();
    rd(3, "R4 occupancy four", 8'h04);
    rd(0, "R4 cav set no ovf", 8'h20);
    push1();
    rd(0, "R3 fifth cell overflow", 8'h60);
    rd(3, "R3 occupancy stays", 8'h04);
    wr(0, 8'hFF);
    rd(0, "R4 cav ignores status w1c", 8'h20);
    wr(3, 8'h01);
    rd(0, "R4 ack clears cav", 8'h00);
    rd(3, "R4 ack pops", 8'h03);
    @(negedge clk); cq_push = 1; wr_en = 1; addr = 3; wdata = 8'h01;
    @(negedge clk); cq_push = 0; wr_en = 0;
    rd(0, "R7 push beats ack", 8'h20);
    rd(3, "R7 push with ack occupancy", 8'h03);
    for (int k = 0; k < 3; k++) wr(3, 8'h01);
    rd(3, "R4 drained", 8'h00);
    wr(3, 8'h01);
    rd(3, "R4 ack on empty", 8'h00);

    // R9 R10 grant timeout, limit 3
    wr(2, 8'h03);
    rd(2, "R9 limit readback", 8'h03);
    tick_n(4);
    rd(0, "R9 no request no timeout", 8'h00);
    @(negedge clk); bus_req = 1;
    tick_n(2);
    rd(0, "R9 before limit", 8'h00);
    tick_n(1);
    rd(0, "R9 at limit", 8'h04);
    wr(0, 8'h04);
    tick_n(5);
    rd(0, "R10 once per request", 8'h00);
    @(negedge clk); bus_req = 0;
    @(negedge clk); bus_req = 1;
    tick_n(2);
    @(negedge clk); bus_gnt = 1;
    @(negedge clk); bus_gnt = 0;
    tick_n(2);
    rd(0, "R10 grant restarts count", 8'h00);
    tick_n(1);
    rd(0, "R10 after restart", 8'h04);
    wr(0, 8'h04);
    wr(2, 8'h00);
    @(negedge clk); bus_req = 0;
    @(negedge clk); bus_req = 1;
    tick_n(1);
    rd(0, "R9 limit zero acts as one", 8'h04);
    @(negedge clk); bus_req = 0;
    wr(0, 8'h04);

    // R11 reserved bit
    wr(0, 8'h02);
    rd(0, "R11 reserved after write", 8'h00);
    @(negedge clk); hdr_chk = 1; hdr_crc_rx = 4'h1; inlet_soc_err = 1; ctl_sent = 1; outlet_ovf = 1;
    @(negedge clk); hdr_chk = 0; inlet_soc_err = 0; ctl_sent = 0; outlet_ovf = 0;
    rd(0, "R11 reserved with all events", 8'h99);

    // R1 reset again mid-run
    wr(1, 8'hFF);
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);
    rd(0, "R1 status after reset", 8'h00);
    rd(1, "R1 enable after reset", 8'h00);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule